// File: doc/BRIEF.md
# Compressed-Stream Sync Word Detector

This block watches a stream of 16-bit sample words, as carried on a PCM-format audio link, and recognises the six-word preamble that announces a compressed, non-PCM data burst. The preamble is four all-zero words, then 0xF872, then 0x4E1F. The block looks only at the sample values. It ignores any audio/non-audio status flag that the link may also carry.

Each time the preamble completes, the block raises a one-cycle pulse so that downstream logic can count burst starts. It also sets a sticky detection flag. The flag stays high while preambles keep recurring. It drops once a programmable number of accepted words has passed with no new preamble. Words arrive with a valid strobe, and cycles without the strobe have no effect. A synchronous reset clears all state.

Top module: `burst_sync_detector`

## Requirements
- R1: While `rst` is high at a clock edge, `detect_o` and `match_pulse_o` are 0 after that edge.
- R2: When the six most recently accepted words (those with `valid_i` high) are 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F, in that order, the edge that accepts 0x4E1F sets `match_pulse_o` and `detect_o` to 1, with no further cycle of delay.
- R3: A cycle with `valid_i` low does not advance the search, does not break a partly seen preamble, and leaves `detect_o` unchanged. `match_pulse_o` is 0 after such a cycle.
- R4: A 0xF872 that follows fewer than four consecutive accepted zero words does not lead to a match, even if 0x4E1F follows it.
- R5: A run of more than four zero words before 0xF872, 0x4E1F still produces a match.
- R6: When a preamble is broken, the search starts again. The word that broke it counts as the first word of a possible new preamble, so 0x0000 ×4, 0xF872, 0x0000 ×4, 0xF872, 0x4E1F gives exactly one match.
- R7: Every complete preamble clears the idle count, so `detect_o` stays 1 while preambles recur within TIMEOUT accepted words of each other.
- R8: With `detect_o` high and no new match, `detect_o` stays 1 through the (TIMEOUT−1)-th accepted word after the last matching word. It goes to 0 at the edge that accepts the TIMEOUT-th such word.
- R9: `match_pulse_o` is high for exactly one cycle per completed preamble and at no other time.
- R10: A reset in the middle of a preamble discards the words seen before it, so a preamble split across a reset does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Qualifies `word_i` in this cycle |
| word_i | input | 16 | Sample word |
| detect_o | output | 1 | Sticky flag: compressed stream present |
| match_pulse_o | output | 1 | One-cycle pulse on each completed preamble |

## Verification
The checker assumes that `valid_i` is low whenever `rst` is high. It also assumes that a new word can arrive in every cycle, with no minimum spacing. The bench holds the strobe low throughout reset. It changes inputs only on the falling edge, and it mixes back-to-back words with gaps of idle cycles so that both assumptions are tested. The timeout is shortened to 20 words so that the flag's expiry can be reached many times. Every zero-run length from 0 to 7 is swept against a correct tail and against each broken tail.

// File: rtl/burst_sync_detector.sv
module burst_sync_detector #(
  parameter int WORD_W = 16,
  parameter int LEAD_ZEROS = 4,
  parameter logic [WORD_W-1:0] SYNC_P = 16'hF872,
  parameter logic [WORD_W-1:0] SYNC_Q = 16'h4E1F,
  parameter int TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              detect_o,
  output logic              match_pulse_o
);
  localparam int ZC_W = $clog2(LEAD_ZEROS + 1);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  logic [ZC_W-1:0] zrun;
  logic            armed;
  logic [TO_W-1:0] idle;
  logic            det_q, pulse_q;

  wire is_zero  = (word_i == '0);
  wire full_run = (zrun == ZC_W'(LEAD_ZEROS));
  wire hit      = valid_i && armed && (word_i == SYNC_Q);

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun    <= '0;
      armed   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (valid_i) begin
        armed <= !armed && full_run && (word_i == SYNC_P);
        if (is_zero)
          zrun <= full_run ? zrun : zrun + 1'b1;
        else
          zrun <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= 1'b0;
      idle  <= '0;
    end else if (hit) begin
      det_q <= 1'b1;
      idle  <= '0;
    end else if (valid_i && det_q) begin
      if (idle == TO_W'(TIMEOUT - 1)) begin
        det_q <= 1'b0;
        idle  <= '0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end

  assign detect_o      = det_q;
  assign match_pulse_o = pulse_q;
endmodule

// File: rtl/burst_sync_detector_chk.sv
module burst_sync_detector_chk #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] SYNC_Q = 16'h4E1F
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              detect_o,
  input logic              match_pulse_o
);
  p_pulse_flag_r2: assert property (@(posedge clk) disable iff (rst)
    match_pulse_o |-> detect_o);
  p_pulse_word_r2: assert property (@(posedge clk) disable iff (rst)
    match_pulse_o |-> ($past(valid_i) && $past(word_i) == SYNC_Q));
  p_rise_by_match_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(detect_o) |-> match_pulse_o);
  p_gap_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(detect_o) && !match_pulse_o));
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    match_pulse_o |=> !match_pulse_o);
endmodule

bind burst_sync_detector burst_sync_detector_chk #(.WORD_W(WORD_W), .SYNC_Q(SYNC_Q)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .word_i(word_i),
  .detect_o(detect_o), .match_pulse_o(match_pulse_o)
);

// File: tb/tb_burst_sync_detector.sv
module tb_burst_sync_detector;
  localparam int TO = 20;
  logic clk = 0, rst = 0, vld = 0;
  logic [15:0] wd = '0;
  logic detect_o, match_pulse_o;
  int checks = 0, errors = 0, seen_p = 0, exp_p = 0, cnt = 0;
  logic exp_det = 0;
  logic [15:0] hist [0:5];

  burst_sync_detector #(.TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .valid_i(vld), .word_i(wd),
    .detect_o(detect_o), .match_pulse_o(match_pulse_o));

  always #5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 6; i++) hist[i] = 16'hFFFF;
    exp_det = 0; cnt = 0;
  endtask

  task automatic step(input logic v, input logic [15:0] w, input string tag);
    logic m;
    @(negedge clk); vld = v; wd = w; m = 0;
    if (v) begin
      for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
      hist[5] = w;
      m = hist[0] == 0 && hist[1] == 0 && hist[2] == 0 && hist[3] == 0 &&
          hist[4] == 16'hF872 && hist[5] == 16'h4E1F;
      if (m) begin exp_det = 1; cnt = 0; end
      else if (exp_det) begin
        cnt++;
        if (cnt == TO) begin exp_det = 0; cnt = 0; end
      end
    end
    if (m) exp_p++;
    @(posedge clk); #2;
    if (match_pulse_o) seen_p++;
    chk(detect_o, exp_det, {tag, " detect"});
    chk(match_pulse_o, m, {tag, " pulse"});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; vld = 0;
    repeat (2) @(posedge clk);
    #2;
    chk(detect_o, 0, "R1 reset detect");
    chk(match_pulse_o, 0, "R1 reset pulse");
    @(negedge clk); rst = 0;
    model_clear();
  endtask

  task automatic burst(input int zeros, input string tag);
    for (int i = 0; i < zeros; i++) step(1, 16'h0000, tag);
    step(1, 16'hF872, tag);
    step(1, 16'h4E1F, tag);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_clear();
    do_reset();
    burst(4, "R2 exact");
    chk(detect_o, 1, "R2 flag after preamble");
    repeat (3) step(1, 16'h5555, "R2 tail");
    burst(3, "R4 short run");
    burst(7, "R5 long run");
    burst(4, "R6 prefix");
    burst(4, "R6 resync");
    for (int i = 0; i < 4; i++) begin step(1, 16'h0000, "R3 gaps"); step(0, 16'hF872, "R3 gaps"); step(0, 16'h4E1F, "R3 gaps"); end
    step(1, 16'hF872, "R3 gaps"); step(0, 16'h0000, "R3 gaps"); step(1, 16'h4E1F, "R3 gaps");
    for (int k = 0; k < 6; k++) begin
      burst(4, "R7 recur");
      repeat (8) step(1, 16'h1234, "R7 recur");
      chk(detect_o, 1, "R7 held between bursts");
    end
    burst(4, "R8 arm");
    for (int i = 0; i < TO - 1; i++) step(1, 16'h5555, "R8 idle");
    chk(detect_o, 1, "R8 before expiry");
    step(0, 16'h5555, "R8 gap");
    chk(detect_o, 1, "R8 gap no count");
    step(1, 16'h5555, "R8 expiry");
    chk(detect_o, 0, "R8 cleared at timeout");
    for (int z = 0; z < 8; z++)
      for (int t = 0; t < 3; t++) begin
        for (int i = 0; i < z; i++) step(1, 16'h0000, "R4_R5 sweep");
        step(1, t == 1 ? 16'h1234 : 16'hF872, "R4_R5 sweep");
        step(1, t == 2 ? 16'h4E1E : 16'h4E1F, "R4_R5 sweep");
        repeat (2) step(1, 16'h5555, "R4_R5 sweep");
      end
    repeat (3) step(1, 16'h0000, "R10 pre");
    do_reset();
    step(1, 16'h0000, "R10 post"); step(1, 16'hF872, "R10 post"); step(1, 16'h4E1F, "R10 post");
    chk(match_pulse_o, 0, "R10 split preamble");
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:1])
        2'd0, 2'd1: w = 16'h0000;
        2'd2: w = 16'hF872;
        default: w = 16'h4E1F;
      endcase
      if (lf[8:5] == 0) w = 16'h0000;
      step(lf[4:3] != 0, w, "R6 R3 mixed");
    end
    checks++;
    if (seen_p != exp_p) begin
      errors++;
      $display("FAIL R9 pulse count actual=%0d expected=%0d", seen_p, exp_p);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule